// File: doc/BRIEF.md
# Address Region Decoder with One-Way Boot Remap

This block sorts every processor request into one of three address regions. The lowest 4 MB belong to internal RAM and the highest 4 MB belong to on-chip peripherals. Everything in between belongs to the external bus, which is divided into chip-select banks. The decode is combinational and lines up with the request-valid cycle. It gives a region select, a chip-select index for external hits, and an abort pulse for external addresses that no usable bank claims. Peripheral accesses always leave the block as whole-word accesses at a word-aligned address.

After reset the low 4 MB alias the boot device on chip select 0, so the processor can fetch its vectors from non-volatile memory. Software issues a remap command once. From then on the low region maps to internal RAM, where the vectors can be rewritten, and chip selects other than 0 become reachable. The remap state has no way back except a reset.

Each chip select has a base expressed in megabytes, a size code from 1 MB to 16 MB and an enable bit, all written through a configuration port. The block also samples a boot-width strap while the external reset is held and keeps that value.

Top module: `addr_region_decode`

## Requirements
- R1: After remap, a valid request whose address bits [31:22] are all zero asserts `sel_ram_o` only, with no abort.
- R2: Before remap, a valid request to the low 4 MB asserts `sel_ext_o` with `cs_idx_o` = 0 and no abort.
- R3: A valid request whose address bits [31:22] are all ones asserts `sel_per_o` and never aborts. `bus_addr_o` equals the request address with bits [1:0] cleared, and `bus_size_o` = 2 (word), whatever size was requested (0 byte, 1 half-word, 2 word).
- R4: After remap, a middle-region address that falls inside an enabled bank asserts `sel_ext_o` with `cs_idx_o` equal to that bank's index.
- R5: A middle-region address that no bank covers, or whose claiming bank is disabled, asserts `abort_o` only.
- R6: Before remap, a middle-region address claimed by a bank other than 0 aborts.
- R7: When banks overlap, the lowest-numbered bank claims the address, even when it is disabled.
- R8: A bank with size code k (0..4) covers 2^k MB starting at its base rounded down to a 2^k MB boundary. Codes 5 to 7 behave as code 4 (16 MB). Configuration writes take effect from the next cycle.
- R9: A remap command sets `remap_o` on the next clock edge. `remap_o` then stays set until a reset.
- R10: A soft reset clears the remap state and restores the bank reset configuration (bank 0 enabled at 16 MB, 1 MB size; the others disabled). `boot_narrow_o` holds the strap value last sampled while `rst_n` was low and is not changed by a soft reset.
- R11: While `req_valid_i` is low, all selects and the abort are low.
- R12: For non-peripheral requests, `bus_addr_o` and `bus_size_o` equal the request address and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| soft_rst_i | input | 1 | Internal synchronous reset |
| boot_narrow_i | input | 1 | Boot-width strap (1 = 8-bit boot device) |
| remap_cmd_i | input | 1 | Remap command pulse |
| cfg_we_i | input | 1 | Bank configuration write strobe |
| cfg_idx_i | input | IDX_W | Bank being written |
| cfg_base_mb_i | input | ADDR_W-20 | Bank base in MB units |
| cfg_size_i | input | 3 | Bank size code |
| cfg_en_i | input | 1 | Bank enable |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | ADDR_W | Request address |
| req_size_i | input | 2 | Request size (0 byte, 1 half, 2 word) |
| req_write_i | input | 1 | Request is a write |
| sel_ram_o | output | 1 | Internal RAM selected |
| sel_ext_o | output | 1 | External bank selected |
| sel_per_o | output | 1 | Peripheral space selected |
| cs_idx_o | output | IDX_W | Chip-select index for external hits |
| abort_o | output | 1 | Undefined external address |
| bus_addr_o | output | ADDR_W | Address issued downstream |
| bus_size_o | output | 2 | Size issued downstream |
| bus_write_o | output | 1 | Write flag issued downstream |
| remap_o | output | 1 | Remap state |
| boot_narrow_o | output | 1 | Latched boot-width strap |

## Verification
The assertions assume that `req_addr_i` and `req_size_i` are stable and known for as long as `req_valid_i` is high. They also assume that `soft_rst_i` is a clean synchronous pulse and that the strap is only meaningful while `rst_n` is low. The bench changes inputs only on falling edges and samples the combinational decode in the same half-cycle. It issues configuration writes and commands as single-cycle pulses, keeps request sizes in the legal range 0 to 2, and drives the strap only while the external reset is held.

// File: rtl/ardec_pkg.sv
package ardec_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   localparam int REGION_SHIFT = 22;  // 4 MB region granule
   localparam int MB_SHIFT     = 20;  // bank base granule
   localparam int MAX_SIZE_CODE = 4;  // 16 MB ceiling
endpackage

// File: rtl/ardec_cs_bank.sv
module ardec_cs_bank
   import ardec_pkg::*;
#(
   parameter int MB_W     = 12,
   parameter int RST_EN   = 0,
   parameter int RST_BASE = 0,
   parameter int RST_SIZE = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_rst,
   input  logic            wr_en,
   input  logic [MB_W-1:0] wr_base,
   input  logic [2:0]      wr_size,
   input  logic            wr_enable,
   input  logic [MB_W-1:0] addr_mb,
   output logic            hit,
   output logic            enabled
);
   logic [MB_W-1:0] base_q;
   logic [2:0]      size_q;
   logic            en_q;
   logic [2:0]      size_eff;
   logic [MB_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= MB_W'(RST_BASE);
         size_q <= 3'(RST_SIZE);
         en_q   <= (RST_EN != 0);
      end else if (soft_rst) begin
         base_q <= MB_W'(RST_BASE);
         size_q <= 3'(RST_SIZE);
         en_q   <= (RST_EN != 0);
      end else if (wr_en) begin
         base_q <= wr_base;
         size_q <= wr_size;
         en_q   <= wr_enable;
      end
   end

   always_comb begin
      size_eff = (size_q > 3'(MAX_SIZE_CODE)) ? 3'(MAX_SIZE_CODE) : size_q;
      mask     = {MB_W{1'b1}} << size_eff;
      hit      = ((addr_mb & mask) == (base_q & mask));
      enabled  = en_q;
   end
endmodule

// File: rtl/ardec_remap_ctl.sv
module ardec_remap_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic remap_cmd,
   input  logic boot_pin,
   output logic remap,
   output logic boot_narrow
);
   logic remap_q;
   logic boot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          remap_q <= 1'b0;
      else if (soft_rst)   remap_q <= 1'b0;
      else if (remap_cmd)  remap_q <= 1'b1;
   end

   // strap sampled only while the external reset holds
   always_ff @(posedge clk) begin
      if (!rst_n) boot_q <= boot_pin;
   end

   assign remap       = remap_q;
   assign boot_narrow = boot_q;
endmodule

// File: rtl/ardec_word_align.sv
module ardec_word_align
   import ardec_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter bit PER_WORD_ONLY = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [1:0]        size_in,
   input  logic              is_per,
   output logic [ADDR_W-1:0] addr_out,
   output logic [1:0]        size_out
);
   generate
      if (PER_WORD_ONLY) begin : g_force_word
         always_comb begin
            addr_out = is_per ? {addr_in[ADDR_W-1:2], 2'b00} : addr_in;
            size_out = is_per ? SZ_WORD : size_in;
         end
      end else begin : g_addr_only
         always_comb begin
            addr_out = is_per ? {addr_in[ADDR_W-1:2], 2'b00} : addr_in;
            size_out = size_in;
         end
      end
   endgenerate
endmodule

// File: rtl/addr_region_decode.sv
module addr_region_decode
   import ardec_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int NUM_CS         = 8,
   parameter int BOOT_BASE_MB   = 16,
   parameter int BOOT_SIZE_CODE = 0,
   parameter bit PER_WORD_ONLY  = 1'b1,
   localparam int MB_W  = ADDR_W - MB_SHIFT,
   localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic              boot_narrow_i,
   input  logic              remap_cmd_i,
   input  logic              cfg_we_i,
   input  logic [IDX_W-1:0]  cfg_idx_i,
   input  logic [MB_W-1:0]   cfg_base_mb_i,
   input  logic [2:0]        cfg_size_i,
   input  logic              cfg_en_i,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [1:0]        req_size_i,
   input  logic              req_write_i,
   output logic              sel_ram_o,
   output logic              sel_ext_o,
   output logic              sel_per_o,
   output logic [IDX_W-1:0]  cs_idx_o,
   output logic              abort_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [1:0]        bus_size_o,
   output logic              bus_write_o,
   output logic              remap_o,
   output logic              boot_narrow_o
);
   localparam int REG_W = ADDR_W - REGION_SHIFT;

   generate
      if (ADDR_W < 24 || ADDR_W > 48) begin : g_bad_addr
         $error("addr_region_decode: ADDR_W out of range");
      end
      if (NUM_CS < 1 || NUM_CS > 16) begin : g_bad_cs
         $error("addr_region_decode: NUM_CS out of range");
      end
      if (BOOT_SIZE_CODE < 0 || BOOT_SIZE_CODE > 7) begin : g_bad_boot
         $error("addr_region_decode: BOOT_SIZE_CODE out of range");
      end
   endgenerate

   logic [NUM_CS-1:0] bank_hit;
   logic [NUM_CS-1:0] bank_en;
   logic [MB_W-1:0]   addr_mb;
   logic              in_low, in_top;
   logic              any_hit, hit_en;
   logic [IDX_W-1:0]  hit_idx;
   logic              ext_ok;
   logic              remap_w;

   assign addr_mb = req_addr_i[ADDR_W-1:MB_SHIFT];
   assign in_low  = (req_addr_i[ADDR_W-1:REGION_SHIFT] == '0);
   assign in_top  = &req_addr_i[ADDR_W-1:REGION_SHIFT];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CS; gi++) begin : g_bank
         ardec_cs_bank #(
            .MB_W    (MB_W),
            .RST_EN  ((gi == 0) ? 1 : 0),
            .RST_BASE((gi == 0) ? BOOT_BASE_MB : 0),
            .RST_SIZE((gi == 0) ? BOOT_SIZE_CODE : 0)
         ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst_i),
            .wr_en    (cfg_we_i && (cfg_idx_i == IDX_W'(gi))),
            .wr_base  (cfg_base_mb_i),
            .wr_size  (cfg_size_i),
            .wr_enable(cfg_en_i),
            .addr_mb  (addr_mb),
            .hit      (bank_hit[gi]),
            .enabled  (bank_en[gi])
         );
      end
   endgenerate

   // lowest index claims the address
   always_comb begin
      any_hit = 1'b0;
      hit_en  = 1'b0;
      hit_idx = '0;
      for (int i = NUM_CS - 1; i >= 0; i--) begin
         if (bank_hit[i]) begin
            any_hit = 1'b1;
            hit_en  = bank_en[i];
            hit_idx = IDX_W'(i);
         end
      end
   end

   ardec_remap_ctl u_remap (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst_i),
      .remap_cmd  (remap_cmd_i),
      .boot_pin   (boot_narrow_i),
      .remap      (remap_w),
      .boot_narrow(boot_narrow_o)
   );

   assign ext_ok = any_hit && hit_en && (remap_w || (hit_idx == '0));

   always_comb begin
      sel_ram_o = 1'b0;
      sel_ext_o = 1'b0;
      sel_per_o = 1'b0;
      abort_o   = 1'b0;
      cs_idx_o  = '0;
      if (req_valid_i) begin
         if (in_top) begin
            sel_per_o = 1'b1;
         end else if (in_low) begin
            if (remap_w) sel_ram_o = 1'b1;
            else         sel_ext_o = 1'b1;
         end else if (ext_ok) begin
            sel_ext_o = 1'b1;
            cs_idx_o  = hit_idx;
         end else begin
            abort_o = 1'b1;
         end
      end
   end

   ardec_word_align #(
      .ADDR_W       (ADDR_W),
      .PER_WORD_ONLY(PER_WORD_ONLY)
   ) u_align (
      .addr_in (req_addr_i),
      .size_in (req_size_i),
      .is_per  (in_top),
      .addr_out(bus_addr_o),
      .size_out(bus_size_o)
   );

   assign bus_write_o = req_write_i;
   assign remap_o     = remap_w;

   logic unused_reg;
   assign unused_reg = ^REG_W;
endmodule

// File: rtl/ardec_chk.sv
module ardec_chk #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst_i,
   input logic              remap_cmd_i,
   input logic              req_valid_i,
   input logic [ADDR_W-1:0] req_addr_i,
   input logic              sel_ram_o,
   input logic              sel_ext_o,
   input logic              sel_per_o,
   input logic              abort_o,
   input logic [IDX_W-1:0]  cs_idx_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic [1:0]        bus_size_o,
   input logic              remap_o,
   input logic              boot_narrow_o
);
   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |-> !(sel_ram_o || sel_ext_o || sel_per_o || abort_o));

   // R5
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |-> ($countones({sel_ram_o, sel_ext_o, sel_per_o, abort_o}) == 1));

   // R3
   per_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_per_o |-> (bus_addr_o[1:0] == 2'b00 && bus_size_o == 2'd2 && !abort_o));

   // R1
   ram_needs_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ram_o |-> remap_o);

   // R6
   early_cs0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ext_o && !remap_o) |-> (cs_idx_o == '0));

   // R9
   remap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (remap_cmd_i && !soft_rst_i) |=> remap_o);

   // R9
   remap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (remap_o && !soft_rst_i) |=> remap_o);

   // R10
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_i |=> !remap_o);

   // R10
   boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(boot_narrow_o));

   // R12
   passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !sel_per_o) |-> (bus_addr_o == req_addr_i));
endmodule

bind addr_region_decode ardec_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .soft_rst_i   (soft_rst_i),
   .remap_cmd_i  (remap_cmd_i),
   .req_valid_i  (req_valid_i),
   .req_addr_i   (req_addr_i),
   .sel_ram_o    (sel_ram_o),
   .sel_ext_o    (sel_ext_o),
   .sel_per_o    (sel_per_o),
   .abort_o      (abort_o),
   .cs_idx_o     (cs_idx_o),
   .bus_addr_o   (bus_addr_o),
   .bus_size_o   (bus_size_o),
   .remap_o      (remap_o),
   .boot_narrow_o(boot_narrow_o)
);

// File: tb/addr_region_decode_test.sv
`timescale 1ns/1ps
module addr_region_decode_test;
   localparam int NCS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst_i = 1'b0;
   logic        boot_narrow_i = 1'b1;
   logic        remap_cmd_i = 1'b0;
   logic        cfg_we_i = 1'b0;
   logic [2:0]  cfg_idx_i = '0;
   logic [11:0] cfg_base_mb_i = '0;
   logic [2:0]  cfg_size_i = '0;
   logic        cfg_en_i = 1'b0;
   logic        req_valid_i = 1'b0;
   logic [31:0] req_addr_i = '0;
   logic [1:0]  req_size_i = '0;
   logic        req_write_i = 1'b0;
   logic        sel_ram_o, sel_ext_o, sel_per_o, abort_o;
   logic [2:0]  cs_idx_o;
   logic [31:0] bus_addr_o;
   logic [1:0]  bus_size_o;
   logic        bus_write_o, remap_o, boot_narrow_o;

   int checks = 0;
   int failures = 0;

   logic [11:0] m_base [NCS];
   logic [2:0]  m_size [NCS];
   logic        m_en   [NCS];
   logic        m_remap;

   always #5 clk = ~clk;

   addr_region_decode uut (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
      .boot_narrow_i(boot_narrow_i), .remap_cmd_i(remap_cmd_i),
      .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_base_mb_i(cfg_base_mb_i),
      .cfg_size_i(cfg_size_i), .cfg_en_i(cfg_en_i),
      .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
      .req_size_i(req_size_i), .req_write_i(req_write_i),
      .sel_ram_o(sel_ram_o), .sel_ext_o(sel_ext_o), .sel_per_o(sel_per_o),
      .cs_idx_o(cs_idx_o), .abort_o(abort_o), .bus_addr_o(bus_addr_o),
      .bus_size_o(bus_size_o), .bus_write_o(bus_write_o),
      .remap_o(remap_o), .boot_narrow_o(boot_narrow_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NCS; i++) begin
         m_base[i] = (i == 0) ? 12'h010 : 12'h000;
         m_size[i] = 3'd0;
         m_en[i]   = (i == 0);
      end
      m_remap = 1'b0;
   endtask

   task automatic program_bank(input int idx, input logic [11:0] base,
                               input logic [2:0] sz, input logic en);
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_idx_i = 3'(idx); cfg_base_mb_i = base;
      cfg_size_i = sz; cfg_en_i = en;
      @(negedge clk);
      cfg_we_i = 1'b0;
      m_base[idx] = base; m_size[idx] = sz; m_en[idx] = en;
   endtask

   // expected {ram,ext,per,abort,idx[2:0],size[1:0]} and a tag
   task automatic expect_of(input logic [31:0] a, input logic [1:0] sz,
                            output logic [8:0] e, output string tag);
      logic [11:0] mb;
      int hit;
      int k;
      logic [11:0] msk;
      mb  = a[31:20];
      hit = -1;
      if (a[31:22] == 10'h3FF) begin
         e = {4'b0010, 3'd0, 2'd2}; tag = "R3";
      end else if (a[31:22] == 10'h000) begin
         if (m_remap) begin e = {4'b1000, 3'd0, sz}; tag = "R1"; end
         else         begin e = {4'b0100, 3'd0, sz}; tag = "R2"; end
      end else begin
         for (int i = NCS - 1; i >= 0; i--) begin
            k   = (m_size[i] > 3'd4) ? 4 : int'(m_size[i]);
            msk = 12'hFFF << k;
            if ((mb & msk) == (m_base[i] & msk)) hit = i;
         end
         if (hit >= 0 && m_en[hit] && (m_remap || hit == 0)) begin
            e = {4'b0100, 3'(hit), sz}; tag = "R4/R7/R8";
         end else if (hit > 0 && m_en[hit] && !m_remap) begin
            e = {4'b0001, 3'd0, sz}; tag = "R6";
         end else begin
            e = {4'b0001, 3'd0, sz}; tag = "R5";
         end
      end
   endtask

   task automatic access(input logic [31:0] a, input logic [1:0] sz);
      logic [8:0] e;
      string tag;
      logic [31:0] ea;
      @(negedge clk);
      req_valid_i = 1'b1; req_addr_i = a; req_size_i = sz; req_write_i = a[2];
      #2;
      expect_of(a, sz, e, tag);
      chk(tag, {55'd0, sel_ram_o, sel_ext_o, sel_per_o, abort_o, cs_idx_o, bus_size_o},
          {55'd0, e});
      ea = (a[31:22] == 10'h3FF) ? {a[31:2], 2'b00} : a;
      chk((a[31:22] == 10'h3FF) ? "R3" : "R12", {32'd0, bus_addr_o}, {32'd0, ea});
   endtask

   task automatic sweep();
      for (int mb = 0; mb < 12'h200; mb++)
         access({12'(mb), 20'((mb * 32'h9E37) & 32'hFFFFF)}, 2'(mb % 3));
      for (int mb = 12'hFF0; mb <= 12'hFFF; mb++)
         access({12'(mb), 20'((mb * 32'h1D3) & 32'hFFFFF) | 20'h3}, 2'(mb % 3));
   endtask

   task automatic idle_check(input string req);
      @(negedge clk);
      req_valid_i = 1'b0; req_addr_i = 32'hFFC0_0001;
      #2;
      chk(req, {60'd0, sel_ram_o, sel_ext_o, sel_per_o, abort_o}, 64'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      model_reset();
      repeat (4) @(negedge clk);
      boot_narrow_i = 1'b0;   // last sampled value in reset is 1 below
      @(negedge clk);
      boot_narrow_i = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      boot_narrow_i = 1'b0;   // changes after release must not be seen
      #2;
      chk("R10 boot strap", {63'd0, boot_narrow_o}, 64'd1);
      chk("R9 reset remap", {63'd0, remap_o}, 64'd0);
      idle_check("R11");

      // reset configuration: bank0 at 16 MB before any write
      access(32'h0100_0040, 2'd2);
      access(32'h0000_0010, 2'd0);

      program_bank(1, 12'h020, 3'd1, 1'b1);  // 2 MB
      program_bank(2, 12'h040, 3'd4, 1'b1);  // 16 MB
      program_bank(3, 12'h048, 3'd0, 1'b1);  // R7 overlaps bank2, loses
      program_bank(4, 12'h085, 3'd7, 1'b1);  // R8 code 7 clamps to 16 MB
      program_bank(5, 12'h0A0, 3'd2, 1'b0);  // disabled
      program_bank(6, 12'h0C3, 3'd2, 1'b1);  // R8 base rounds down
      program_bank(7, 12'h100, 3'd3, 1'b1);

      sweep();   // before remap: R2 and R6

      @(negedge clk); remap_cmd_i = 1'b1;
      @(negedge clk); remap_cmd_i = 1'b0; m_remap = 1'b1;
      #2 chk("R9 remap set", {63'd0, remap_o}, 64'd1);
      repeat (5) @(negedge clk);
      #2 chk("R9 remap sticky", {63'd0, remap_o}, 64'd1);

      sweep();   // after remap: R1, R4, R5, R7, R8
      idle_check("R11 after remap");

      @(negedge clk); soft_rst_i = 1'b1;
      @(negedge clk); soft_rst_i = 1'b0; model_reset();
      #2;
      chk("R10 soft clears remap", {63'd0, remap_o}, 64'd0);
      chk("R10 soft keeps strap", {63'd0, boot_narrow_o}, 64'd1);
      @(negedge clk); remap_cmd_i = 1'b1;
      @(negedge clk); remap_cmd_i = 1'b0; m_remap = 1'b1;
      access(32'h0200_0000, 2'd2);  // R10 bank1 config gone: abort
      access(32'h0100_0004, 2'd1);  // R10 bank0 restored
      access(32'h0000_0020, 2'd2);  // R1

      // external reset with strap low
      @(negedge clk); rst_n = 1'b0; boot_narrow_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; boot_narrow_i = 1'b1; model_reset();
      #2;
      chk("R10 strap resampled", {63'd0, boot_narrow_o}, 64'd0);
      chk("R9 ext reset clears remap", {63'd0, remap_o}, 64'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule